// File: doc/BRIEF.md
# Video Controller Control-Port Decoder

This block sits behind the control port of a video display controller. Every word written to that port is classified. A word whose two top bits are `10` updates one of the controller's 24 eight-bit configuration registers. Any other word is one half of a two-word access command. The first half is held until its partner arrives. From the two halves the block gathers a 6-bit access code and a 16-bit destination address. It also works out which internal memory the command targets.

The block starts transfers but does not carry them out. When a completed command asks for a copy inside video RAM, it pulses a copy request. When it asks for a transfer from system memory, it pulses a memory-transfer request, unless the source-select bit in register 23 blocks that. A later data-port write while a fill command is active captures the fill word and pulses a fill request. The port takes either a single 16-bit word or a 32-bit double write, which carries two words at once.

Top module: `vdc_ctrl_decoder`

## Requirements
- R1: A 16-bit control word with bits [15:14] = 2'b10 writes bits [7:0] into the register selected by bits [12:8]. Bit 13 is ignored. The register outputs show the new value one clock after the write.
- R2: A register write whose index is 24 to 31 changes no register.
- R3: A 32-bit control write carries its first word in bits [31:16] and its second word in bits [15:0]. If the first word is a register write, it is applied. The second word is then applied only if it is also a register write, and it wins when both words select the same index. A second word that is not a register write is dropped and leaves the pending state unchanged.
- R4: A 16-bit non-register word arriving when no first word is held is stored, and `cmd_pending` rises on the next clock. The next non-register 16-bit word completes the command and clears `cmd_pending`. A register write arriving in between updates its register and keeps the held word.
- R5: A 32-bit control write whose first word is not a register write forms a complete command from its two words. This holds even when a first word is already held, and the held word is then discarded with `cmd_pending` cleared.
- R6: On completion, `cmd_code` = {second[7:4], first[15:14]} and `cmd_addr` = {second[1:0], first[13:0]}. Both are visible one clock after the completing write.
- R7: `cmd_target` is 0 (video RAM) when code[3:1] = 0, 2 (scroll RAM) when code[3:1] = 2, and 1 (colour RAM) for every other value.
- R8: A completed command with code[5] = 1 and code[4] = 1 pulses `copy_req` for one clock, in the same cycle that the new code appears.
- R9: A completed command with code[5] = 1 and code[4] = 0 pulses `mem_req` for one clock, but only when bit 7 of register 23 is 0 at the time of the completing write.
- R10: A data-port write made while the current code has bits [5:4] = 2'b10 loads `fill_value` with the data word and pulses `fill_req` one clock later. A data write under any other code changes neither output.
- R11: `cmd_code`, `cmd_addr` and `cmd_target` hold their values on every clock that completes no command.
- R12: Synchronous reset clears all registers, the held word, `cmd_pending`, the code, address, target, fill value and all request pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control-port write strobe |
| ctrl_wide | input | 1 | 1 = 32-bit double write, 0 = single 16-bit word in bits [15:0] |
| ctrl_wdata | input | 32 | Control write data |
| data_we | input | 1 | Data-port write strobe |
| data_wdata | input | 16 | Data-port write word |
| regs_flat | output | 192 | Register bank; register i occupies bits [8i+7:8i] |
| cmd_pending | output | 1 | A first command word is held |
| cmd_code | output | 6 | Access code of the last complete command |
| cmd_addr | output | 16 | Destination address of the last complete command |
| cmd_target | output | 2 | Target memory: 0 video RAM, 1 colour RAM, 2 scroll RAM |
| copy_req | output | 1 | One-clock video-RAM copy request |
| mem_req | output | 1 | One-clock memory-transfer request |
| fill_req | output | 1 | One-clock fill request |
| fill_value | output | 16 | Last captured fill word |

## Verification
Some properties are checked on every clock by assertions: the held word is released on completion, the command outputs stay put when nothing completes, the copy and memory requests never fire together, a fill pulse always follows a data write, and an out-of-range register write leaves the bank unchanged. Other behaviours appear only in the bench scenarios. These are the exact bit scattering of code and address, the target decode, the gating of memory requests by register 23, a register write slipped between two command halves, a 32-bit command overriding a held half, and a lower word dropped from a double register write.

// File: rtl/vdc_ctrl_pkg.sv
package vdc_ctrl_pkg;

    localparam int WORD_W = 16;
    localparam int CODE_W = 6;
    localparam int ADDR_W = 16;
    localparam int REG_W  = 8;
    localparam int IDX_W  = 5;
    localparam int DMA_SRC_REG = 23;

    typedef enum logic [1:0] {
        TGT_VRAM = 2'd0,
        TGT_CRAM = 2'd1,
        TGT_SRAM = 2'd2
    } vdc_target_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [ADDR_W-1:0] addr;
    } vdc_cmd_t;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic [REG_W-1:0] val;
    } vdc_regwr_t;

    function automatic logic is_reg_word(input logic [WORD_W-1:0] w);
        return w[15:14] == 2'b10;
    endfunction

    function automatic vdc_regwr_t reg_wr_of(input logic [WORD_W-1:0] w);
        vdc_regwr_t r;
        r.en  = 1'b1;
        r.idx = w[12:8];
        r.val = w[7:0];
        return r;
    endfunction

    function automatic vdc_cmd_t merge_cmd(input logic [WORD_W-1:0] first,
                                           input logic [WORD_W-1:0] second);
        vdc_cmd_t c;
        c.code = {second[7:4], first[15:14]};
        c.addr = {second[1:0], first[13:0]};
        return c;
    endfunction

    function automatic vdc_target_e target_of(input logic [CODE_W-1:0] code);
        case (code[3:1])
            3'd0:    return TGT_VRAM;
            3'd2:    return TGT_SRAM;
            default: return TGT_CRAM;
        endcase
    endfunction

endpackage

// File: rtl/vdc_reg_bank.sv
module vdc_reg_bank
    import vdc_ctrl_pkg::*;
#(
    parameter int NUM_REGS = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  vdc_regwr_t wr_a,
    input  vdc_regwr_t wr_b,
    output logic [NUM_REGS-1:0][REG_W-1:0] regs
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_b.en && int'(wr_b.idx) == i)
                    regs[i] <= wr_b.val;
                else if (wr_a.en && int'(wr_a.idx) == i)
                    regs[i] <= wr_a.val;
            end
        end
    end

    // R2
    bad_index_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_a.en && int'(wr_a.idx) >= NUM_REGS && !wr_b.en) |=> $stable(regs));

endmodule

// File: rtl/vdc_cmd_assembler.sv
module vdc_cmd_assembler
    import vdc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_we,
    input  logic [WORD_W-1:0] word,
    input  logic              pair_we,
    input  logic [WORD_W-1:0] pair_first,
    input  logic [WORD_W-1:0] pair_second,
    input  logic              mem_src_block,
    output logic              pending,
    output vdc_cmd_t          cmd,
    output vdc_target_e       target,
    output logic              copy_req,
    output logic              mem_req
);

    logic [WORD_W-1:0] first_q;
    logic              complete;
    vdc_cmd_t          next_cmd;

    always_comb begin
        complete = pair_we || (word_we && pending);
        next_cmd = pair_we ? merge_cmd(pair_first, pair_second)
                           : merge_cmd(first_q, word);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending  <= 1'b0;
            first_q  <= '0;
            cmd      <= '0;
            target   <= TGT_VRAM;
            copy_req <= 1'b0;
            mem_req  <= 1'b0;
        end else begin
            copy_req <= 1'b0;
            mem_req  <= 1'b0;
            if (complete) begin
                pending  <= 1'b0;
                cmd      <= next_cmd;
                target   <= target_of(next_cmd.code);
                copy_req <= next_cmd.code[5] && next_cmd.code[4];
                mem_req  <= next_cmd.code[5] && !next_cmd.code[4] && !mem_src_block;
            end else if (word_we) begin
                first_q <= word;
                pending <= 1'b1;
            end
        end
    end

    // R4
    pending_release_chk: assert property (@(posedge clk) disable iff (rst)
        (word_we && !pair_we && pending) |=> !pending);

    // R5
    pair_clears_pending_chk: assert property (@(posedge clk) disable iff (rst)
        pair_we |=> !pending);

    // R11
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!word_we && !pair_we) |=> ($stable(cmd) && $stable(target)));

    // R8
    req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(copy_req && mem_req));

    // R9
    mem_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_src_block && complete) |=> !mem_req);

endmodule

// File: rtl/vdc_fill_trigger.sv
module vdc_fill_trigger
    import vdc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              data_we,
    input  logic [WORD_W-1:0] data_word,
    input  logic [CODE_W-1:0] code,
    output logic              fill_req,
    output logic [WORD_W-1:0] fill_value
);

    logic fill_armed;

    always_comb fill_armed = (code[5:4] == 2'b10);

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_req   <= 1'b0;
            fill_value <= '0;
        end else begin
            fill_req <= data_we && fill_armed;
            if (data_we && fill_armed)
                fill_value <= data_word;
        end
    end

    // R10
    fill_after_data_chk: assert property (@(posedge clk) disable iff (rst)
        fill_req |-> $past(data_we));

    // R10
    fill_value_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !data_we |=> $stable(fill_value));

endmodule

// File: rtl/vdc_ctrl_decoder.sv
module vdc_ctrl_decoder
    import vdc_ctrl_pkg::*;
#(
    parameter int NUM_REGS = 24
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ctrl_we,
    input  logic                      ctrl_wide,
    input  logic [31:0]               ctrl_wdata,
    input  logic                      data_we,
    input  logic [15:0]               data_wdata,
    output logic [NUM_REGS*REG_W-1:0] regs_flat,
    output logic                      cmd_pending,
    output logic [5:0]                cmd_code,
    output logic [15:0]               cmd_addr,
    output logic [1:0]                cmd_target,
    output logic                      copy_req,
    output logic                      mem_req,
    output logic                      fill_req,
    output logic [15:0]               fill_value
);

    logic [WORD_W-1:0] w_hi, w_lo;
    vdc_regwr_t        wr_a, wr_b;
    logic              word_we, pair_we;
    logic [NUM_REGS-1:0][REG_W-1:0] bank;
    vdc_cmd_t          cmd;
    vdc_target_e       target;

    always_comb begin
        w_hi    = ctrl_wdata[31:16];
        w_lo    = ctrl_wdata[15:0];
        wr_a    = '0;
        wr_b    = '0;
        word_we = 1'b0;
        pair_we = 1'b0;
        if (ctrl_we) begin
            if (!ctrl_wide) begin
                if (is_reg_word(w_lo)) wr_a = reg_wr_of(w_lo);
                else                   word_we = 1'b1;
            end else if (is_reg_word(w_hi)) begin
                wr_a = reg_wr_of(w_hi);
                if (is_reg_word(w_lo)) wr_b = reg_wr_of(w_lo);
            end else begin
                pair_we = 1'b1;
            end
        end
    end

    vdc_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .wr_a (wr_a),
        .wr_b (wr_b),
        .regs (bank)
    );

    vdc_cmd_assembler u_cmd (
        .clk           (clk),
        .rst           (rst),
        .word_we       (word_we),
        .word          (w_lo),
        .pair_we       (pair_we),
        .pair_first    (w_hi),
        .pair_second   (w_lo),
        .mem_src_block (bank[DMA_SRC_REG][7]),
        .pending       (cmd_pending),
        .cmd           (cmd),
        .target        (target),
        .copy_req      (copy_req),
        .mem_req       (mem_req)
    );

    vdc_fill_trigger u_fill (
        .clk        (clk),
        .rst        (rst),
        .data_we    (data_we),
        .data_word  (data_wdata),
        .code       (cmd.code),
        .fill_req   (fill_req),
        .fill_value (fill_value)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign regs_flat[g*REG_W +: REG_W] = bank[g];
    end

    assign cmd_code   = cmd.code;
    assign cmd_addr   = cmd.addr;
    assign cmd_target = target;

    // R1
    reg_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && !ctrl_wide && is_reg_word(ctrl_wdata[15:0]) && ctrl_wdata[12:8] == 5'd1)
        |=> (regs_flat[15:8] == $past(ctrl_wdata[7:0])));

endmodule

// File: tb/vdc_ctrl_decoder_tb.sv
`timescale 1ns/1ps
module vdc_ctrl_decoder_tb;

    localparam int NR = 24;

    logic        clk = 1'b0;
    logic        rst;
    logic        ctrl_we, ctrl_wide, data_we;
    logic [31:0] ctrl_wdata;
    logic [15:0] data_wdata;
    logic [NR*8-1:0] regs_flat;
    logic        cmd_pending, copy_req, mem_req, fill_req;
    logic [5:0]  cmd_code;
    logic [15:0] cmd_addr, fill_value;
    logic [1:0]  cmd_target;

    always #2 clk = ~clk;

    vdc_ctrl_decoder #(.NUM_REGS(NR)) u_dut (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wide(ctrl_wide),
        .ctrl_wdata(ctrl_wdata), .data_we(data_we), .data_wdata(data_wdata),
        .regs_flat(regs_flat), .cmd_pending(cmd_pending), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .cmd_target(cmd_target), .copy_req(copy_req),
        .mem_req(mem_req), .fill_req(fill_req), .fill_value(fill_value)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // behavioural reference state
    logic [7:0]  m_regs [NR];
    bit          m_pend;
    logic [15:0] m_first;
    logic [5:0]  m_code;
    logic [15:0] m_addr;
    int          m_tgt;
    bit          m_copy, m_mem, m_fill;
    logic [15:0] m_fillv;

    task automatic chk(input string tag, input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NR; i++) m_regs[i] = 8'h00;
        m_pend = 0; m_first = 0; m_code = 0; m_addr = 0; m_tgt = 0;
        m_copy = 0; m_mem = 0; m_fill = 0; m_fillv = 0;
    endtask

    task automatic model_regwr(input logic [15:0] w);
        int idx;
        idx = int'(w[12:8]);
        if (idx < NR) m_regs[idx] = w[7:0];
    endtask

    task automatic model_complete(input logic [15:0] f, input logic [15:0] s);
        int sel;
        m_code = {s[7:4], f[15:14]};
        m_addr = {s[1:0], f[13:0]};
        sel = int'(m_code[3:1]);
        m_tgt = (sel == 0) ? 0 : ((sel == 2) ? 2 : 1);
        m_copy = m_code[5] && m_code[4];
        m_mem  = m_code[5] && !m_code[4] && (m_regs[23][7] == 1'b0);
        m_pend = 0;
    endtask

    task automatic model_step(input bit cwe, input bit wide, input logic [31:0] cd,
                              input bit dwe, input logic [15:0] dd);
        logic [15:0] hi, lo;
        hi = cd[31:16]; lo = cd[15:0];
        m_copy = 0; m_mem = 0; m_fill = 0;
        if (dwe && m_code[5:4] == 2'b10) begin
            m_fill = 1; m_fillv = dd;
        end
        if (cwe) begin
            if (!wide) begin
                if (lo[15:14] == 2'b10) model_regwr(lo);
                else if (m_pend) model_complete(m_first, lo);
                else begin m_first = lo; m_pend = 1; end
            end else if (hi[15:14] == 2'b10) begin
                model_regwr(hi);
                if (lo[15:14] == 2'b10) model_regwr(lo);
            end else begin
                model_complete(hi, lo);
            end
        end
    endtask

    task automatic compare_all();
        logic [191:0] exp_flat;
        for (int i = 0; i < NR; i++) exp_flat[i*8 +: 8] = m_regs[i];
        chk("R1 R2 R3 registers", regs_flat, exp_flat);
        chk("R4 R5 pending", 192'(cmd_pending), 192'(m_pend));
        chk("R6 R11 code", 192'(cmd_code), 192'(m_code));
        chk("R6 R11 addr", 192'(cmd_addr), 192'(m_addr));
        chk("R7 target", 192'(cmd_target), 192'(m_tgt));
        chk("R8 copy_req", 192'(copy_req), 192'(m_copy));
        chk("R9 mem_req", 192'(mem_req), 192'(m_mem));
        chk("R10 fill_req", 192'(fill_req), 192'(m_fill));
        chk("R10 fill_value", 192'(fill_value), 192'(m_fillv));
    endtask

    // called at a negative edge; returns at the next negative edge after checking
    task automatic step(input bit cwe, input bit wide, input logic [31:0] cd,
                        input bit dwe, input logic [15:0] dd);
        ctrl_we = cwe; ctrl_wide = wide; ctrl_wdata = cd;
        data_we = dwe; data_wdata = dd;
        @(posedge clk);
        model_step(cwe, wide, cd, dwe, dd);
        @(negedge clk);
        ctrl_we = 0; ctrl_wide = 0; ctrl_wdata = 0; data_we = 0; data_wdata = 0;
        compare_all();
    endtask

    task automatic w16(input logic [15:0] w);
        step(1, 0, {16'h0, w}, 0, 16'h0);
    endtask
    task automatic w32(input logic [31:0] w);
        step(1, 1, w, 0, 16'h0);
    endtask
    task automatic dwr(input logic [15:0] d);
        step(0, 0, 32'h0, 1, d);
    endtask
    task automatic idle();
        step(0, 0, 32'h0, 0, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; ctrl_we = 0; ctrl_wide = 0; ctrl_wdata = 0; data_we = 0; data_wdata = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R12 reset state
        chk("R12 reset regs", regs_flat, 192'h0);
        chk("R12 reset pending", 192'(cmd_pending), 192'h0);
        chk("R12 reset code/addr", 192'({cmd_code, cmd_addr, cmd_target}), 192'h0);
        chk("R12 reset pulses", 192'({copy_req, mem_req, fill_req, fill_value}), 192'h0);

        // R1 register writes, bit 13 ignored
        w16(16'h8114);
        w16(16'h9705);
        w16(16'hA234);
        chk("R1 reg1 value", 192'(regs_flat[15:8]), 192'h14);
        // R2 out-of-range indices
        w16(16'h9FAA);
        w16(16'hB8AA);
        // R3 double register writes
        w32(32'h8F02_8C81);
        w32(32'h8233_4000);
        chk("R3 lower non-register dropped", 192'(cmd_pending), 192'h0);
        w32(32'h8511_8522);
        chk("R3 same index second wins", 192'(regs_flat[47:40]), 192'h22);
        // R4 R6 R7 two-word commands
        w16(16'h4000);
        chk("R4 pending after first", 192'(cmd_pending), 192'h1);
        w16(16'h0000);
        chk("R7 vram target", 192'(cmd_target), 192'h0);
        w16(16'hC000); w16(16'h0000);
        chk("R7 cram target", 192'(cmd_target), 192'h1);
        w16(16'h4000); w16(16'h0010);
        chk("R7 scroll target", 192'(cmd_target), 192'h2);
        w16(16'h7FFF); w16(16'h0003);
        chk("R6 addr full", 192'(cmd_addr), 192'hFFFF);
        // R4 register write between halves
        w16(16'h4123); w16(16'h8A10); idle(); w16(16'h0002);
        // R8 copy
        w16(16'h0000); w16(16'h00C0);
        idle();
        // R9 memory transfer allowed then blocked
        w32(32'h4000_0080);
        w16(16'h9780);
        w32(32'h4000_0080);
        // R10 fill
        dwr(16'hBEEF);
        chk("R10 fill value", 192'(fill_value), 192'hBEEF);
        idle();
        w32(32'h4000_0000);
        dwr(16'h1234);
        // R10 data write in the completion cycle uses the old code
        w32(32'h4000_0080);
        step(1, 1, 32'h4000_0000, 1, 16'h5555);
        // R5 pair overrides held word
        w16(16'h4000);
        w32(32'h6000_0003);
        idle(); idle();
        // mixed traffic
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [31:0] r;
            op = int'($urandom_range(0, 5));
            r = $urandom;
            case (op)
                0: w16({2'b10, r[13:0]});
                1: w16(r[15:0]);
                2: w32(r);
                3: w32({2'b10, r[29:16], 2'b10, r[13:0]});
                4: dwr(r[15:0]);
                default: step(1, r[20], r, 1, r[31:16]);
            endcase
        end
        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule